// File: doc/BRIEF.md
# Banked Level-Interrupt Controller

This block gathers level-sensitive interrupt inputs into a configurable number of banks of 32 sources each. Every source has a sticky pending bit that is captured on any clock where its input is high. Software picks which sources may interrupt through a per-bank enable word and acknowledges a serviced source by writing a one to its pending bit. Each bank drives one request line. That line is raised while any pending and enabled source exists in the bank.

Software reaches each bank through a single-cycle register port. The bank register sets repeat at a fixed address stride. Each bank also offers a masked view of its pending bits. Beside the request, each bank presents the index of its highest-numbered pending enabled source and a flag that marks the index as meaningful, so a handler can go straight to the right source. Two further words per bank, a resend word and a mask word, are plain storage: they are writable and readable for initialisation code and do not affect the request logic.

Top module: `icu_multibank`

## Requirements
- R1: A synchronous reset clears every register of every bank to zero. After reset, all reads return zero, every request line is low and every index-valid flag is low.
- R2: Bank b occupies byte addresses b*0x28 up to b*0x28+0x27. Within a bank, the registers are at these offsets: pending 0x00, enable 0x08, masked-pending 0x10, resend 0x18 and mask 0x20. All registers are 32 bits wide, and bit n of a register belongs to source n of that bank.
- R3: A pending bit is set at the first clock edge where its source input is sampled high, and it stays set after the input falls.
- R4: Writing a word to the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. If a source is high in the same cycle as a clear of its bit, the bit stays set.
- R5: The enable, resend and mask registers take full 32-bit writes and read back the written value.
- R6: The masked-pending register reads as pending AND enable. It is read-only, and a write to it changes no register.
- R7: The request line of a bank is high exactly when its masked-pending word is non-zero. The line rises in the cycle after the edge that sets the pending bit or the enable bit.
- R8: Each bank outputs a 5-bit index of the most significant set bit of its masked-pending word and a valid flag that is high when that word is non-zero. The index reads 0 when the word is zero.
- R9: A read of an offset within a bank that is not listed in R2, or of an address past the last bank, returns zero, and a write to such an address changes nothing.
- R10: Banks are independent. A write or source activity in one bank changes no register, request or index of another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, from the current register state |
| src_i | input | NUM_BANKS*32 (128) | Level interrupt inputs, bank b at bits [b*32+31:b*32] |
| irq_o | output | NUM_BANKS (4) | Per-bank request lines |
| top_idx_o | output | NUM_BANKS*IDX_W (20) | Per-bank highest pending enabled source index |
| top_vld_o | output | NUM_BANKS (4) | Per-bank index-valid flags |

## Verification
The assertions check every cycle that:
- each request line matches the OR of pending AND enable;
- the valid flag tracks the request;
- the reported index is the top set bit, and is zero when idle;
- a high source always leaves its pending bit set on the next edge;
- pending bits fall only in cycles with a write.

Only the bench scenarios can show the following, because they need known write data and addresses:
- the address map and stride;
- full-word read-back of the storage words;
- write-one-to-clear against write-zero;
- the read-only masked view;
- the silence of unmapped addresses;
- isolation between banks.

// File: rtl/icu_mb_pkg.sv
`timescale 1ns/1ps
package icu_mb_pkg;

    localparam int unsigned WORD_W = 32;

    // register offsets inside one bank window
    localparam int unsigned OFF_PEND  = 0;
    localparam int unsigned OFF_ENA   = 8;
    localparam int unsigned OFF_MPEND = 16;
    localparam int unsigned OFF_RSND  = 24;
    localparam int unsigned OFF_MASK  = 32;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_ENA,
        SEL_MPEND,
        SEL_RSND,
        SEL_MASK
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] pend;
        logic [WORD_W-1:0] ena;
        logic [WORD_W-1:0] rsnd;
        logic [WORD_W-1:0] mask;
    } bank_regs_t;

    function automatic reg_sel_e off_to_sel(input int unsigned off);
        reg_sel_e s;
        case (off)
            OFF_PEND:  s = SEL_PEND;
            OFF_ENA:   s = SEL_ENA;
            OFF_MPEND: s = SEL_MPEND;
            OFF_RSND:  s = SEL_RSND;
            OFF_MASK:  s = SEL_MASK;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/icu_mb_decode.sv
`timescale 1ns/1ps
module icu_mb_decode
    import icu_mb_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned STRIDE    = 40,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BANK_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [BANK_W-1:0] bank,
    output reg_sel_e          sel
);

    // range compare per bank window instead of a divider (R2, R9)
    always_comb begin
        int unsigned addr_u;
        int unsigned off;
        addr_u = 32'(addr);
        off    = 0;
        bank   = '0;
        sel    = SEL_NONE;
        for (int unsigned b = 0; b < NUM_BANKS; b++) begin
            if (addr_u >= b * STRIDE && addr_u < (b + 1) * STRIDE) begin
                bank = BANK_W'(b);
                off  = addr_u - b * STRIDE;
                sel  = off_to_sel(off);
            end
        end
        hit = (sel != SEL_NONE);
    end

endmodule

// File: rtl/icu_mb_bank.sv
`timescale 1ns/1ps
module icu_mb_bank
    import icu_mb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] src,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    output bank_regs_t        regs,
    output logic [WORD_W-1:0] mpend,
    output logic              irq
);

    bank_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (sel)
                SEL_PEND:  regs_d.pend = regs_q.pend & ~wdata;  // R4 write-one-to-clear
                SEL_ENA:   regs_d.ena  = wdata;                 // R5
                SEL_RSND:  regs_d.rsnd = wdata;                 // R5
                SEL_MASK:  regs_d.mask = wdata;                 // R5
                default:   ;                                    // R6 masked view is read-only
            endcase
        end
        // level capture after the clear, so a live source wins (R3, R4)
        regs_d.pend = regs_d.pend | src;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;                                       // R1
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs  = regs_q;
    assign mpend = regs_q.pend & regs_q.ena;                    // R6
    assign irq   = |mpend;                                      // R7

endmodule

// File: rtl/icu_mb_msb.sv
`timescale 1ns/1ps
module icu_mb_msb #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             vld
);

    // ascending scan: the last set bit seen is the most significant (R8)
    always_comb begin
        idx = '0;
        vld = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                vld = 1'b1;
            end
        end
    end

endmodule

// File: rtl/icu_multibank.sv
`timescale 1ns/1ps
module icu_multibank
    import icu_mb_pkg::*;
#(
    parameter int unsigned NUM_BANKS   = 4,
    parameter int unsigned BANK_STRIDE = 40,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned IDX_W       = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [WORD_W-1:0]             bus_wdata,
    output logic [WORD_W-1:0]             bus_rdata,
    input  logic [NUM_BANKS*WORD_W-1:0]   src_i,
    output logic [NUM_BANKS-1:0]          irq_o,
    output logic [NUM_BANKS*IDX_W-1:0]    top_idx_o,
    output logic [NUM_BANKS-1:0]          top_vld_o
);

    localparam int unsigned SRC_W  = NUM_BANKS * WORD_W;
    localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic              dec_hit;
    logic [BANK_W-1:0] dec_bank;
    reg_sel_e          dec_sel;

    bank_regs_t        regs [NUM_BANKS];
    logic [WORD_W-1:0] mpend [NUM_BANKS];
    logic [SRC_W-1:0]  stat_all;
    logic [SRC_W-1:0]  en_all;

    icu_mb_decode #(
        .NUM_BANKS (NUM_BANKS),
        .STRIDE    (BANK_STRIDE),
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W)
    ) u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .bank (dec_bank),
        .sel  (dec_sel)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic wr_g;
        assign wr_g = bus_we && dec_hit && (dec_bank == BANK_W'(g));   // R10

        icu_mb_bank u_bank (
            .clk   (clk),
            .rst   (rst),
            .src   (src_i[g*WORD_W +: WORD_W]),
            .wr_en (wr_g),
            .sel   (dec_sel),
            .wdata (bus_wdata),
            .regs  (regs[g]),
            .mpend (mpend[g]),
            .irq   (irq_o[g])
        );

        icu_mb_msb #(
            .W     (WORD_W),
            .IDX_W (IDX_W)
        ) u_msb (
            .vec (mpend[g]),
            .idx (top_idx_o[g*IDX_W +: IDX_W]),
            .vld (top_vld_o[g])
        );

        assign stat_all[g*WORD_W +: WORD_W] = regs[g].pend;
        assign en_all[g*WORD_W +: WORD_W]   = regs[g].ena;
    end

    // read mux; unmapped addresses give zero (R9)
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec_hit && dec_bank == BANK_W'(b)) begin
                case (dec_sel)
                    SEL_PEND:  bus_rdata = regs[b].pend;
                    SEL_ENA:   bus_rdata = regs[b].ena;
                    SEL_MPEND: bus_rdata = mpend[b];
                    SEL_RSND:  bus_rdata = regs[b].rsnd;
                    SEL_MASK:  bus_rdata = regs[b].mask;
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/icu_mb_chk.sv
`timescale 1ns/1ps
module icu_mb_chk #(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned IDX_W     = 5
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_we,
    input logic [NUM_BANKS*32-1:0]    src_i,
    input logic [NUM_BANKS*32-1:0]    stat_all,
    input logic [NUM_BANKS*32-1:0]    en_all,
    input logic [NUM_BANKS-1:0]       irq_o,
    input logic [NUM_BANKS*IDX_W-1:0] top_idx_o,
    input logic [NUM_BANKS-1:0]       top_vld_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (stat_all == '0 && en_all == '0 && irq_o == '0)); // R1

    AST_SRC_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_all & $past(src_i)) == $past(src_i))); // R3

    AST_NO_CLEAR_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ((stat_all & $past(stat_all)) == $past(stat_all))); // R4

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        AST_IRQ_FROM_MPEND: assert property (@(posedge clk) disable iff (rst)
            irq_o[b] == |(stat_all[b*32 +: 32] & en_all[b*32 +: 32])); // R7

        AST_VLD_TRACKS_IRQ: assert property (@(posedge clk) disable iff (rst)
            top_vld_o[b] == irq_o[b]); // R8

        AST_IDX_IS_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
            top_vld_o[b] |-> (((stat_all[b*32 +: 32] & en_all[b*32 +: 32])
                                >> top_idx_o[b*IDX_W +: IDX_W]) == 32'd1)); // R8

        AST_IDX_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
            !top_vld_o[b] |-> (top_idx_o[b*IDX_W +: IDX_W] == '0)); // R8
    end

endmodule

bind icu_multibank icu_mb_chk #(
    .NUM_BANKS (NUM_BANKS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .src_i     (src_i),
    .stat_all  (stat_all),
    .en_all    (en_all),
    .irq_o     (irq_o),
    .top_idx_o (top_idx_o),
    .top_vld_o (top_vld_o)
);

// File: tb/icu_multibank_tb.sv
`timescale 1ns/1ps
module icu_multibank_tb;

    localparam int NB   = 4;
    localparam int STR  = 40;
    localparam int IDXW = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NB*32-1:0]  src_i = '0;
    logic [NB-1:0]     irq_o;
    logic [NB*IDXW-1:0] top_idx_o;
    logic [NB-1:0]     top_vld_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    icu_multibank u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_i     (src_i),
        .irq_o     (irq_o),
        .top_idx_o (top_idx_o),
        .top_vld_o (top_vld_o)
    );

    // kind 0: read data, 1: request vector, 2: {valid,index} of a bank
    typedef struct {
        int          kind;
        int          bank;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];

    function automatic logic [7:0] ad(input int bank, input int off);
        return 8'(bank * STR + off);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = a;
        it.kind = 0; it.bank = 0; it.exp = e; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic chk_irq(input logic [NB-1:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.kind = 1; it.bank = 0; it.exp = 32'(e); it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic chk_idx(input int b, input bit v, input int idx, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.kind = 2; it.bank = b; it.exp = 32'(v) * 32 + 32'(idx); it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic pulse(input int bit_i);
        @(posedge clk); #1;
        src_i[bit_i] = 1'b1;
        @(posedge clk); #1;
        src_i[bit_i] = 1'b0;
    endtask

    // monitor: compares one queued item per cycle, between clock edges
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = 32'(irq_o);
                    default: act = {26'd0, top_vld_o[it.bank], top_idx_o[it.bank*IDXW +: IDXW]};
                endcase
                compared++;
                if (act !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(ad(0, 0), 32'h0, "R1 pend bank0");
        rd(ad(3, 8), 32'h0, "R1 enable bank3");
        rd(ad(2, 32), 32'h0, "R1 mask bank2");
        chk_irq(4'b0000, "R1 irq");
        for (int b = 0; b < NB; b++) chk_idx(b, 1'b0, 0, "R1 idx");

        // R5 initialisation pattern and read-back
        wr(ad(0, 8), 32'h0);
        wr(ad(0, 0), 32'hFFFF_FFFF);
        wr(ad(0, 32), 32'hFFFF_FFFF);
        wr(ad(0, 24), 32'h0);
        rd(ad(0, 32), 32'hFFFF_FFFF, "R5 mask");
        rd(ad(0, 24), 32'h0, "R5 resend");
        rd(ad(0, 0), 32'h0, "R4 pend after clear-all");
        wr(ad(0, 24), 32'hA5A5_5A5A);
        rd(ad(0, 24), 32'hA5A5_5A5A, "R5 resend pattern");
        wr(ad(1, 8), 32'h0000_00F0);
        rd(ad(1, 8), 32'h0000_00F0, "R5 enable bank1");

        // R3 / R6 / R7 / R8 single source
        pulse(32 + 5);
        rd(ad(1, 0), 32'h0000_0020, "R3 sticky pend");
        rd(ad(1, 16), 32'h0000_0020, "R6 masked view");
        chk_irq(4'b0010, "R7 irq bank1");
        chk_idx(1, 1'b1, 5, "R8 idx 5");

        // disabled source is pending but hidden
        pulse(32 + 2);
        rd(ad(1, 0), 32'h0000_0024, "R3 second source");
        rd(ad(1, 16), 32'h0000_0020, "R6 disabled hidden");
        chk_idx(1, 1'b1, 5, "R8 idx stays 5");

        wr(ad(1, 8), 32'hFFFF_FFFF);
        rd(ad(1, 16), 32'h0000_0024, "R6 after enable");
        pulse(32 + 31);
        chk_idx(1, 1'b1, 31, "R8 idx 31");
        rd(ad(1, 16), 32'h8000_0024, "R6 top bit");

        // R4 write-one-to-clear
        wr(ad(1, 0), 32'h8000_0000);
        rd(ad(1, 0), 32'h0000_0024, "R4 clear top");
        chk_idx(1, 1'b1, 5, "R8 idx back to 5");
        wr(ad(1, 0), 32'h0);
        rd(ad(1, 0), 32'h0000_0024, "R4 zero write keeps");
        wr(ad(1, 0), 32'h0000_0020);
        rd(ad(1, 0), 32'h0000_0004, "R4 clear bit5");
        chk_idx(1, 1'b1, 2, "R8 idx 2");

        // R4 set wins over clear
        @(posedge clk); #1 src_i[32 + 2] = 1'b1;
        wr(ad(1, 0), 32'h0000_0004);
        rd(ad(1, 0), 32'h0000_0004, "R4 set beats clear");
        src_i[32 + 2] = 1'b0;
        wr(ad(1, 0), 32'h0000_0004);
        rd(ad(1, 0), 32'h0, "R4 cleared after source low");
        chk_irq(4'b0000, "R7 irq low");
        chk_idx(1, 1'b0, 0, "R8 idle idx zero");

        // R6 masked view is read-only
        wr(ad(1, 16), 32'hFFFF_FFFF);
        rd(ad(1, 0), 32'h0, "R6 write ignored pend");
        rd(ad(1, 8), 32'hFFFF_FFFF, "R6 write ignored enable");
        rd(ad(1, 16), 32'h0, "R6 view still zero");

        // R9 unmapped
        wr(ad(0, 4), 32'hFFFF_FFFF);
        rd(ad(0, 4), 32'h0, "R9 hole read");
        rd(ad(0, 8), 32'h0, "R9 hole write ignored");
        rd(ad(0, 36), 32'h0, "R9 tail of window");
        wr(8'hA0, 32'hFFFF_FFFF);
        rd(8'hA0, 32'h0, "R9 past last bank");
        rd(8'hFF, 32'h0, "R9 top address");
        rd(ad(3, 8), 32'h0, "R9 no alias into bank3");

        // R2 / R10 stride and isolation
        wr(ad(3, 8), 32'h0000_0200);
        rd(ad(2, 8), 32'h0, "R10 bank2 untouched");
        rd(ad(3, 8), 32'h0000_0200, "R2 bank3 enable at 0x80");
        @(posedge clk); #1 src_i[64] = 1'b1; src_i[96 + 9] = 1'b1;
        @(posedge clk); #1 src_i[64] = 1'b0; src_i[96 + 9] = 1'b0;
        chk_irq(4'b1000, "R10 only bank3 requests");
        rd(ad(2, 0), 32'h0000_0001, "R3 bank2 pend");
        rd(ad(3, 16), 32'h0000_0200, "R2 bank3 masked view");
        chk_idx(3, 1'b1, 9, "R8 bank3 idx 9");
        chk_idx(2, 1'b0, 0, "R10 bank2 idle");
        rd(ad(1, 0), 32'h0, "R10 bank1 pend untouched");

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule